// File: doc/BRIEF.md
# Framed Telemetry Status Serializer

This block sends a 32-bit status word to a telemetry collector one bit per frame
pulse. The status word is built from a 7-bit divider setting and a 20-bit
fine-offset count, with the unused upper bits held at zero. A 5-bit sequence
counter is advanced by every frame pulse. It decides when a fresh nibble is
moved into a 4-bit parallel-load shift register and which nibble that is. The
same pulse shifts that register by one place, so the serial output steps
through the word from its most significant bit downwards.

A separate marker line is high while the first bit of each readout is on the
data line, which lets the collector align each 32-bit readout. The complete
word is captured at the first pulse of a readout. Every nibble of one readout
therefore comes from the same instant, even when the source counters change
partway through. After 32 pulses the sequence counter wraps and the next pulse
starts a new readout with a new capture.

Top module: `tm_status_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tm_data` and `tm_mark` become 0 and the sequence restarts. The first frame pulse after reset begins a new readout.
- R2: The status word has bits [19:0] equal to `fine_cnt`, bits [26:20] equal to `div_n`, and bits [31:27] equal to 0.
- R3: At the k-th frame pulse of a readout (k = 0..31), `tm_data` takes the value of status-word bit 31-k. The new value appears in the clock cycle after the edge that samples the pulse.
- R4: `tm_mark` is 1 after the pulse with k = 0 and 0 after every other pulse.
- R5: The status word is captured from `div_n` and `fine_cnt` at the pulse with k = 0. Input changes during pulses 1..31 do not affect the readout in progress.
- R6: The sequence counter wraps from 31 to 0. The 33rd pulse starts a new readout: the marker is raised and a new capture is taken.
- R7: In clock cycles without a frame pulse, `tm_data` and `tm_mark` hold their values, whatever the word inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | One-cycle frame strobe from the telemetry side |
| div_n | input | 7 | Divider setting placed in word bits [26:20] |
| fine_cnt | input | 20 | Fine-offset count placed in word bits [19:0] |
| tm_data | output | 1 | Serial status bit, most significant first |
| tm_mark | output | 1 | High during the first bit of each readout |

## Verification
The main readout is exercised with four word patterns:
- All ones in both fields, which shows that the five zero pad bits are really zero.
- A single set bit in each field, which exposes misplaced fields or a reversed bit order.
- Alternating bits, which separates a shift from a reload at each nibble boundary.
- A mixed pattern that differs in every nibble.

Two further tests change the inputs in the middle of a readout and between pulses. These show whether the capture is taken once per readout and whether the outputs move only on pulses. A reset issued partway through a readout, followed by back-to-back readouts, checks where the sequence restarts and where it wraps.

// File: rtl/tm_ser_pkg.sv
// Package: shared types for the telemetry status serializer.
// Assumes nothing beyond a single clock domain.
package tm_ser_pkg;

    // Action taken by the nibble shifter on a given clock cycle.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,  // no frame pulse: hold everything
        ACT_START  = 2'd1,  // first bit of a readout: capture and load top nibble
        ACT_RELOAD = 2'd2,  // nibble boundary: load next nibble from snapshot
        ACT_SHIFT  = 2'd3   // inside a nibble: shift one place
    } tm_act_e;

endpackage

// File: rtl/tm_frame_sequencer.sv
// Module: tm_frame_sequencer
// Counts frame pulses modulo the word width. It decodes, for each pulse,
// whether a readout starts, a nibble reload is due, or a plain shift happens,
// and it also names the nibble to reload.
// Assumes WORD_W is a power of two and a multiple of NIB_W, and that
// frame_i is a one-cycle strobe synchronous to clk.
module tm_frame_sequencer
    import tm_ser_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    localparam int SEQ_W  = $clog2(WORD_W),
    localparam int NIB_CNT = WORD_W / NIB_W,
    localparam int NSEL_W = $clog2(NIB_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    output logic [SEQ_W-1:0]  seq_o,
    output tm_act_e           act_o,
    output logic [NSEL_W-1:0] nib_sel_o
);

    localparam int LOW_W = $clog2(NIB_W);
    localparam logic [NSEL_W-1:0] LAST_NIB = NSEL_W'(NIB_CNT - 1);

    logic [SEQ_W-1:0] seq_q;

    // Advance the bit position on each frame pulse; wraps naturally at WORD_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else if (frame_i) begin
            seq_q <= seq_q + 1'b1;
        end
    end

    // Decode the action for this cycle from the pulse and the bit position.
    always_comb begin
        if (!frame_i) begin
            act_o = ACT_IDLE;
        end else if (seq_q == '0) begin
            act_o = ACT_START;
        end else if (seq_q[LOW_W-1:0] == '0) begin
            act_o = ACT_RELOAD;
        end else begin
            act_o = ACT_SHIFT;
        end
    end

    // Nibbles go out most significant first, so invert the nibble index.
    always_comb begin
        nib_sel_o = LAST_NIB - seq_q[SEQ_W-1 -: NSEL_W];
    end

    assign seq_o = seq_q;

endmodule

// File: rtl/tm_word_snapshot.sv
// Module: tm_word_snapshot
// Assembles the status word from the divider setting and the fine count,
// padding unused high bits with zero, and holds a copy taken on capture.
// Assumes N_W + FINE_W <= WORD_W.
module tm_word_snapshot #(
    parameter int N_W    = 7,
    parameter int FINE_W = 20,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [N_W-1:0]    n_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic [WORD_W-1:0] live_o,
    output logic [WORD_W-1:0] snap_o
);

    localparam int USED_W = N_W + FINE_W;
    localparam int PAD_W  = WORD_W - USED_W;

    // Build the live word; pad only when fields leave room.
    generate
        if (PAD_W > 0) begin : g_pad
            assign live_o = {{PAD_W{1'b0}}, n_i, fine_i};
        end else begin : g_nopad
            assign live_o = {n_i, fine_i};
        end
    endgenerate

    logic [WORD_W-1:0] snap_q;

    // Hold the word taken at the start of a readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (capture_i) begin
            snap_q <= live_o;
        end
    end

    assign snap_o = snap_q;

endmodule

// File: rtl/tm_nibble_shifter.sv
// Module: tm_nibble_shifter
// A parallel-load shift register of NIB_W bits whose top bit drives the
// serial line, plus the marker flag for the first bit of a readout.
// On START it loads the top nibble straight from the live word (the snapshot
// is written on the same edge); on RELOAD it loads the selected snapshot
// nibble; on SHIFT it moves one place towards the output.
module tm_nibble_shifter
    import tm_ser_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    localparam int NIB_CNT = WORD_W / NIB_W,
    localparam int NSEL_W  = $clog2(NIB_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tm_act_e           act_i,
    input  logic [WORD_W-1:0] live_i,
    input  logic [WORD_W-1:0] snap_i,
    input  logic [NSEL_W-1:0] nib_sel_i,
    output logic              data_o,
    output logic              mark_o
);

    logic [NIB_W-1:0] sr_q;
    logic             mark_q;
    logic [NIB_W-1:0] reload_nib;

    // Pick the snapshot nibble named by the sequencer.
    always_comb begin
        reload_nib = snap_i[nib_sel_i * NIB_W +: NIB_W];
    end

    // Load or shift the register according to the decoded action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            unique case (act_i)
                ACT_START:  sr_q <= live_i[WORD_W-1 -: NIB_W];
                ACT_RELOAD: sr_q <= reload_nib;
                ACT_SHIFT:  sr_q <= {sr_q[NIB_W-2:0], 1'b0};
                default:    sr_q <= sr_q;
            endcase
        end
    end

    // Raise the marker for the first bit, drop it on any later pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= 1'b0;
        end else if (act_i == ACT_START) begin
            mark_q <= 1'b1;
        end else if (act_i != ACT_IDLE) begin
            mark_q <= 1'b0;
        end
    end

    assign data_o = sr_q[NIB_W-1];
    assign mark_o = mark_q;

endmodule

// File: rtl/tm_status_serializer.sv
// Module: tm_status_serializer (top)
// Serializes a status word made of a divider setting and a fine count,
// one bit per frame pulse, most significant bit first, with a marker on
// the first bit of each readout. Assumes frame_pulse is a one-cycle strobe.
module tm_status_serializer
    import tm_ser_pkg::*;
#(
    parameter int N_W    = 7,
    parameter int FINE_W = 20,
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4,
    localparam int SEQ_W  = $clog2(WORD_W),
    localparam int NSEL_W = $clog2(WORD_W / NIB_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_pulse,
    input  logic [N_W-1:0]    div_n,
    input  logic [FINE_W-1:0] fine_cnt,
    output logic              tm_data,
    output logic              tm_mark
);

    logic [SEQ_W-1:0]  seq_q;
    tm_act_e           act;
    logic [NSEL_W-1:0] nib_sel;
    logic [WORD_W-1:0] live_word;
    logic [WORD_W-1:0] snap_q;
    logic              capture;

    assign capture = (act == ACT_START);

    tm_frame_sequencer #(
        .WORD_W (WORD_W),
        .NIB_W  (NIB_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_i   (frame_pulse),
        .seq_o     (seq_q),
        .act_o     (act),
        .nib_sel_o (nib_sel)
    );

    tm_word_snapshot #(
        .N_W    (N_W),
        .FINE_W (FINE_W),
        .WORD_W (WORD_W)
    ) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .n_i       (div_n),
        .fine_i    (fine_cnt),
        .live_o    (live_word),
        .snap_o    (snap_q)
    );

    tm_nibble_shifter #(
        .WORD_W (WORD_W),
        .NIB_W  (NIB_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act),
        .live_i    (live_word),
        .snap_i    (snap_q),
        .nib_sel_i (nib_sel),
        .data_o    (tm_data),
        .mark_o    (tm_mark)
    );

endmodule

// File: rtl/tm_ser_checker.sv
// Module: tm_ser_checker
// Property checker bound to tm_status_serializer. It keeps its own count of
// frame pulses so that marker placement is judged independently of the
// design's sequence counter.
module tm_ser_checker #(
    parameter int WORD_W = 32,
    parameter int SEQ_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_i,
    input logic [SEQ_W-1:0]  seq_i,
    input logic [WORD_W-1:0] snap_i,
    input logic              data_i,
    input logic              mark_i
);

    logic [SEQ_W-1:0] ck_cnt;

    // Independent pulse counter for marker placement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_cnt <= '0;
        end else if (frame_i) begin
            ck_cnt <= ck_cnt + 1'b1;
        end
    end

    // R1: reset clears both outputs.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!data_i && !mark_i));

    // R4: marker rises on the first pulse of a readout.
    a_r4_mark_first: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && ck_cnt == '0) |=> mark_i);

    // R4: marker is low after any other pulse.
    a_r4_mark_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && ck_cnt != '0) |=> !mark_i);

    // R5: the snapshot does not move during a readout.
    a_r5_snap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_i || seq_i != '0) |=> $stable(snap_i));

    // R6: the sequence counter wraps back to zero after the last bit.
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && seq_i == '1) |=> (seq_i == '0));

    // R7: outputs hold when no pulse arrived.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_i && $past(rst_n)) |=> ($stable(data_i) && $stable(mark_i)));

endmodule

bind tm_status_serializer tm_ser_checker #(
    .WORD_W (WORD_W),
    .SEQ_W  (SEQ_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_i (frame_pulse),
    .seq_i   (seq_q),
    .snap_i  (snap_q),
    .data_i  (tm_data),
    .mark_i  (tm_mark)
);

// File: tb/sim_tm_status_serializer.sv
// Directed bench for tm_status_serializer; one task per scenario.
module sim_tm_status_serializer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_pulse = 1'b0;
    logic [6:0]  div_n = '0;
    logic [19:0] fine_cnt = '0;
    logic        tm_data;
    logic        tm_mark;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tm_status_serializer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .div_n       (div_n),
        .fine_cnt    (fine_cnt),
        .tm_data     (tm_data),
        .tm_mark     (tm_mark)
    );

    function automatic logic [31:0] word_of(input logic [6:0] n, input logic [19:0] f);
        return {5'b00000, n, f};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One frame pulse; returns on the falling edge after the sampling edge.
    task automatic pulse();
        @(negedge clk) frame_pulse = 1'b1;
        @(negedge clk) frame_pulse = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R2 R3 R4: one full readout of the given fields.
    task automatic t_readout(input logic [6:0] n, input logic [19:0] f);
        logic [31:0] w;
        w = word_of(n, f);
        @(negedge clk) begin div_n = n; fine_cnt = f; end
        for (int k = 0; k < 32; k++) begin
            pulse();
            chk($sformatf("R3 R2 bit %0d", k), 32'(tm_data), 32'(w[31-k]));
            chk($sformatf("R4 mark k=%0d", k), 32'(tm_mark), (k == 0) ? 32'd1 : 32'd0);
        end
    endtask

    // R1: reset state, and reset in mid-readout restarts the sequence.
    task automatic t_reset();
        do_reset();
        chk("R1 data after reset", 32'(tm_data), 32'd0);
        chk("R1 mark after reset", 32'(tm_mark), 32'd0);
        div_n = 7'h55; fine_cnt = 20'hF0F0F;
        repeat (5) pulse();
        do_reset();
        chk("R1 data after mid reset", 32'(tm_data), 32'd0);
        chk("R1 mark after mid reset", 32'(tm_mark), 32'd0);
        pulse();
        chk("R1 first pulse starts readout", 32'(tm_mark), 32'd1);
        chk("R1 first bit is word bit 31", 32'(tm_data), 32'd0);
    endtask

    // R5 R6: inputs change mid-readout; next readout uses the new values.
    task automatic t_snapshot();
        logic [31:0] wa, wb;
        do_reset();
        wa = word_of(7'h6B, 20'hA5C3E);
        wb = word_of(7'h14, 20'h5A3C1);
        @(negedge clk) begin div_n = 7'h6B; fine_cnt = 20'hA5C3E; end
        for (int k = 0; k < 32; k++) begin
            pulse();
            if (k == 2) begin div_n = 7'h14; fine_cnt = 20'h5A3C1; end
            chk($sformatf("R5 held bit %0d", k), 32'(tm_data), 32'(wa[31-k]));
        end
        for (int k = 0; k < 32; k++) begin
            pulse();
            if (k == 0) chk("R6 wrap raises mark", 32'(tm_mark), 32'd1);
            chk($sformatf("R6 new readout bit %0d", k), 32'(tm_data), 32'(wb[31-k]));
        end
    endtask

    // R7: no pulse, changing inputs: outputs hold.
    task automatic t_hold();
        logic d0, m0;
        do_reset();
        @(negedge clk) begin div_n = 7'h7F; fine_cnt = 20'hFFFFF; end
        pulse();
        d0 = tm_data; m0 = tm_mark;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) begin div_n = 7'(i); fine_cnt = 20'(i * 3); end
            chk("R7 data held", 32'(tm_data), 32'(d0));
            chk("R7 mark held", 32'(tm_mark), 32'(m0));
        end
        chk("R7 mark set before hold", 32'(m0), 32'd1);
    endtask

    initial begin
        do_reset();
        t_reset();
        do_reset();
        t_readout(7'h7F, 20'hFFFFF);
        t_readout(7'h40, 20'h00001);
        t_readout(7'h2A, 20'hAAAAA);
        t_readout(7'h39, 20'h1E2D3);
        t_snapshot();
        t_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule